// File: doc/BRIEF.md
# Two-Wire Slave with Select-Coded Register Bank

This block is a two-wire serial (I2C) slave. It runs on the system clock and oversamples the bus clock and data lines. The bus lines pass through synchronizers, and edge detectors find clock edges and the START and STOP conditions. The slave answers to one fixed seven-bit device address. It writes to a small bank of control registers, and it returns a status byte when the master reads.

The register select travels inside every data byte; there is no separate subaddress byte:

- The top three bits of each written byte name the target register.
- The low five bits carry the new contents.
- A master may send any number of such bytes after a single address phase. Each byte is decoded and applied on its own.

A read returns the status word: the status select code in the top three bits, then five fault flags sampled from the status inputs.

The data line is open drain, so the block only ever pulls it low through an output enable. While the power-good input is low, the slave acknowledges nothing and writes nothing.

Top module: `lnbctl_i2c_regbank`

## Requirements
- R1: After reset, `tone_q` and `cmd_q` are all zero and `sda_oe` is 0.
- R2: The slave acknowledges an address byte only when its upper seven bits equal 7'b0001000 (bit 0 is the direction: 1 = read, 0 = write). Acknowledging means driving `sda_oe` high through the whole ninth clock. After a non-matching address the slave neither acknowledges nor acts on any byte until the next START.
- R3: In an acknowledged write, a data byte whose bits [7:5] are 3'b001 loads bits [4:0] into `tone_q`. A data byte whose bits [7:5] are 3'b010 loads bits [4:0] into `cmd_q`.
- R4: Several data bytes in one write transfer are each acknowledged and applied in the order they arrive. The last byte that selects a register sets its final value.
- R5: Data bytes with select codes 3'b000 (status, whose payload is read-only) or 3'b011 to 3'b111 are acknowledged but change neither `tone_q` nor `cmd_q`.
- R6: In a read transfer each returned byte is {3'b000, `flags_i`}, sent MSB first. The slave reloads it for each byte the master acknowledges and stops driving after a byte the master does not acknowledge.
- R7: While `pwr_ok_i` is low, the slave acknowledges neither address nor data bytes, and an unacknowledged data byte changes no register.
- R8: After a STOP condition, `sda_oe` is 0.
- R9: `sda_oe` changes only while the synchronized bus clock is low, so the data line the slave drives is stable through every clock-high period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| pwr_ok_i | input | 1 | Supply good; when low, no acknowledge and no write |
| flags_i | input | 5 | Read-only fault flags returned in the status byte |
| tone_q | output | 5 | Payload of the register at select code 001 |
| cmd_q | output | 5 | Payload of the register at select code 010 |

## Verification
The assertions assume a well-behaved bus master:

- It changes the data line only while the clock is low, apart from START and STOP.
- It spaces every line transition more cycles apart than the synchronizer depth, so a clock edge and a data edge never reach the detectors in the same cycle.
- It holds `pwr_ok_i` and `flags_i` steady within each byte.

The stimulus generator meets these assumptions by construction. Each bit takes four quarter periods of eight system clocks. Data changes only in the middle of the low phase. The power and flag inputs are changed only between transfers, or between whole bytes.

// File: rtl/lnbi2c_pkg.sv
package lnbi2c_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;
    localparam int PAY_W  = BYTE_W - SEL_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [SEL_W-1:0] SEL_STATUS = 3'b000;
    localparam logic [SEL_W-1:0] SEL_TONE   = 3'b001;
    localparam logic [SEL_W-1:0] SEL_CMD    = 3'b010;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [PAY_W-1:0] pay;
    } regbyte_t;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_AACK,
        LK_WDATA,
        LK_WACK,
        LK_RDATA,
        LK_RACK
    } lk_state_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [BYTE_W-2:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

    function automatic regbyte_t make_status(input logic [PAY_W-1:0] flags);
        regbyte_t w;
        w.sel = SEL_STATUS;
        w.pay = flags;
        return w;
    endfunction

endpackage

// File: rtl/lnbi2c_sync.sv
module lnbi2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] now_s;
    logic [LINES-1:0] prev_s;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe_q;
        logic              last_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe_q <= '1;
                last_q <= 1'b1;
            end else begin
                pipe_q <= {pipe_q[STAGES-2:0], raw[g]};
                last_q <= pipe_q[STAGES-1];
            end
        end
        assign now_s[g]  = pipe_q[STAGES-1];
        assign prev_s[g] = last_q;
    end

    assign scl_s     = now_s[0];
    assign sda_s     = now_s[1];
    assign scl_rise  = now_s[0] & ~prev_s[0];
    assign scl_fall  = ~now_s[0] & prev_s[0];
    assign start_det = prev_s[1] & ~now_s[1] & now_s[0] & prev_s[0];
    assign stop_det  = ~prev_s[1] & now_s[1] & now_s[0] & prev_s[0];

endmodule

// File: rtl/lnbi2c_link.sv
module lnbi2c_link
    import lnbi2c_pkg::*;
#(
    parameter logic [BYTE_W-2:0] DEV_ADDR = 7'b0001000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    input  logic     scl_rise,
    input  logic     scl_fall,
    input  logic     start_det,
    input  logic     stop_det,
    input  logic     pwr_ok,
    input  regbyte_t status_word,
    output logic     wr_stb,
    output regbyte_t wr_byte,
    output logic     ack_drive,
    output logic     sda_oe
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    lk_state_t         state_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic              rw_q;
    logic              nack_q;
    logic              wr_stb_q;
    regbyte_t          wr_byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= LK_IDLE;
            shreg_q   <= '0;
            bitcnt_q  <= '0;
            rw_q      <= 1'b0;
            nack_q    <= 1'b0;
            wr_stb_q  <= 1'b0;
            wr_byte_q <= '0;
        end else begin
            wr_stb_q <= 1'b0;
            if (start_det) begin
                state_q  <= LK_ADDR;
                bitcnt_q <= '0;
            end else if (stop_det) begin
                state_q <= LK_IDLE;
            end else begin
                unique case (state_q)
                    LK_ADDR, LK_WDATA: begin
                        if (scl_rise && bitcnt_q != FULL) begin
                            shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (scl_fall && bitcnt_q == FULL) begin
                            bitcnt_q <= '0;
                            if (!pwr_ok) begin
                                state_q <= LK_IDLE;
                            end else if (state_q == LK_ADDR) begin
                                if (addr_hit(shreg_q, DEV_ADDR)) begin
                                    state_q <= LK_AACK;
                                    rw_q    <= shreg_q[0];
                                end else begin
                                    state_q <= LK_IDLE;
                                end
                            end else begin
                                state_q   <= LK_WACK;
                                wr_stb_q  <= 1'b1;
                                wr_byte_q <= regbyte_t'(shreg_q);
                            end
                        end
                    end
                    LK_AACK: begin
                        if (scl_fall) begin
                            bitcnt_q <= '0;
                            if (rw_q) begin
                                state_q <= LK_RDATA;
                                shreg_q <= status_word;
                            end else begin
                                state_q <= LK_WDATA;
                            end
                        end
                    end
                    LK_WACK: begin
                        if (scl_fall) begin
                            state_q  <= LK_WDATA;
                            bitcnt_q <= '0;
                        end
                    end
                    LK_RDATA: begin
                        if (scl_rise) begin
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (scl_fall) begin
                            if (bitcnt_q == FULL) begin
                                state_q  <= LK_RACK;
                                bitcnt_q <= '0;
                            end else begin
                                shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    LK_RACK: begin
                        if (scl_rise && scl_s) begin
                            nack_q <= sda_s;
                        end else if (scl_fall) begin
                            if (!nack_q) begin
                                state_q <= LK_RDATA;
                                shreg_q <= status_word;
                            end else begin
                                state_q <= LK_IDLE;
                            end
                        end
                    end
                    default: state_q <= LK_IDLE;
                endcase
            end
        end
    end

    assign ack_drive = (state_q == LK_AACK) || (state_q == LK_WACK);
    assign sda_oe    = ack_drive || ((state_q == LK_RDATA) && !shreg_q[BYTE_W-1]);
    assign wr_stb    = wr_stb_q;
    assign wr_byte   = wr_byte_q;

endmodule

// File: rtl/lnbi2c_regs.sv
module lnbi2c_regs
    import lnbi2c_pkg::*;
#(
    parameter int NUM_WR = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_stb,
    input  regbyte_t                     wr_byte,
    input  logic [PAY_W-1:0]             flags_i,
    output logic [NUM_WR-1:0][PAY_W-1:0] bank_q,
    output regbyte_t                     status_word
);
    for (genvar g = 0; g < NUM_WR; g++) begin : g_bank
        localparam logic [SEL_W-1:0] CODE = SEL_W'(g + 1);
        logic [PAY_W-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
            end else if (wr_stb && wr_byte.sel == CODE) begin
                r_q <= wr_byte.pay;
            end
        end
        assign bank_q[g] = r_q;
    end

    always_comb status_word = make_status(flags_i);

endmodule

// File: rtl/lnbctl_i2c_regbank.sv
module lnbctl_i2c_regbank
    import lnbi2c_pkg::*;
#(
    parameter logic [BYTE_W-2:0] DEV_ADDR    = 7'b0001000,
    parameter int                SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             pwr_ok_i,
    input  logic [PAY_W-1:0] flags_i,
    output logic [PAY_W-1:0] tone_q,
    output logic [PAY_W-1:0] cmd_q
);
    localparam int NUM_WR = 2;

    logic     scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic     wr_stb, ack_drive;
    regbyte_t wr_byte, status_word;
    logic [NUM_WR-1:0][PAY_W-1:0] bank_q;

    lnbi2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    lnbi2c_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .pwr_ok(pwr_ok_i),
        .status_word(status_word), .wr_stb(wr_stb), .wr_byte(wr_byte),
        .ack_drive(ack_drive), .sda_oe(sda_oe)
    );

    lnbi2c_regs #(.NUM_WR(NUM_WR)) u_regs (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_byte(wr_byte),
        .flags_i(flags_i), .bank_q(bank_q), .status_word(status_word)
    );

    assign tone_q = bank_q[0];
    assign cmd_q  = bank_q[1];

endmodule

// File: rtl/lnbi2c_chk.sv
module lnbi2c_chk
    import lnbi2c_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             scl_s,
    input logic             stop_det,
    input logic             sda_oe,
    input logic             ack_drive,
    input logic             pwr_ok_i,
    input logic             wr_stb,
    input regbyte_t         wr_byte,
    input logic [PAY_W-1:0] tone_q,
    input logic [PAY_W-1:0] cmd_q
);
    logic rst_d;
    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d && !rst) begin
            // R1
            reset_clear_chk: assert (tone_q == '0 && cmd_q == '0 && !sda_oe);
        end
    end

    // R7
    ack_pwr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_drive) |-> $past(pwr_ok_i));

    // R9
    sda_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    // R3
    tone_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tone_q) |-> ($past(wr_stb) && $past(wr_byte.sel) == SEL_TONE));

    // R3
    cmd_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmd_q) |-> ($past(wr_stb) && $past(wr_byte.sel) == SEL_CMD));

    // R5
    unused_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_byte.sel != SEL_TONE && wr_byte.sel != SEL_CMD)
        |=> ($stable(tone_q) && $stable(cmd_q)));

endmodule

bind lnbctl_i2c_regbank lnbi2c_chk u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .stop_det(stop_det),
    .sda_oe(sda_oe), .ack_drive(ack_drive), .pwr_ok_i(pwr_ok_i),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .tone_q(tone_q), .cmd_q(cmd_q)
);

// File: tb/lnbctl_i2c_regbank_tb.sv
module lnbctl_i2c_regbank_tb;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pwr_ok = 1'b1;
    logic [4:0] flags = 5'd0;
    logic       sda_oe;
    logic [4:0] tone_q, cmd_q;
    logic       sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    lnbctl_i2c_regbank u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .pwr_ok_i(pwr_ok), .flags_i(flags), .tone_q(tone_q), .cmd_q(cmd_q)
    );

    int total = 0;
    int bad = 0;
    logic [4:0] e_tone = 5'd0;
    logic [4:0] e_cmd = 5'd0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_addr_ack(input logic [7:0] ab, input logic p);
        return (ab[7:1] == 7'b0001000) && p;
    endfunction

    task automatic apply_write(input logic [7:0] b);
        if (b[7:5] == 3'b001) e_tone = b[4:0];
        else if (b[7:5] == 3'b010) e_cmd = b[4:0];
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, output logic got, output logic stable);
        wait_q();
        sda_m = b;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        got = sda_bus;
        wait_q();
        stable = (sda_bus == got);
        scl_m = 1'b0;
    endtask

    task automatic i2c_start();
        wait_q();
        sda_m = 1'b1;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        sda_m = 1'b0;
        wait_q();
        scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        wait_q();
        sda_m = 1'b0;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        sda_m = 1'b1;
        wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic st);
        logic g, s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], g, s);
        clock_bit(1'b1, g, s);
        ack = !g;
        st = s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic g, s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, g, s);
            d[i] = g;
        end
        clock_bit(!mack, g, s);
    endtask

    task automatic finish_regs(input string tag);
        i2c_stop();
        repeat (4) @(negedge clk);
        chk({tag, " R8 released after stop"}, sda_oe, 0);
        chk({tag, " tone_q"}, tone_q, e_tone);
        chk({tag, " cmd_q"}, cmd_q, e_cmd);
    endtask

    task automatic write_xfer(input logic [7:0] ab, input int n,
                              input logic [7:0] d0, input logic [7:0] d1,
                              input logic [7:0] d2, input string tag);
        logic a, st, live;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        i2c_start();
        send_byte(ab, a, st);
        live = exp_addr_ack(ab, pwr_ok);
        chk({tag, " R2 address ack"}, a, live);
        if (live) chk({tag, " R9 ack stable in high phase"}, st, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], a, st);
            chk({tag, " data ack"}, a, live && pwr_ok);
            if (live && pwr_ok) apply_write(d[i]);
            else live = 1'b0;
        end
        finish_regs(tag);
    endtask

    task automatic read_xfer(input logic [7:0] ab, input int n, input string tag);
        logic a, st, live;
        logic [7:0] got;
        i2c_start();
        send_byte(ab, a, st);
        live = exp_addr_ack(ab, pwr_ok);
        chk({tag, " R2 address ack"}, a, live);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, got);
            chk({tag, " R6 read byte"}, got, live ? {3'b000, flags} : 8'hFF);
        end
        finish_regs(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic a, st;
        void'($urandom(32'd4021));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 tone_q reset", tone_q, 0);
        chk("R1 cmd_q reset", cmd_q, 0);
        chk("R1 sda_oe reset", sda_oe, 0);

        // R3
        write_xfer(8'h10, 1, 8'h36, 8'h00, 8'h00, "R3 tone write");
        write_xfer(8'h10, 1, 8'h4B, 8'h00, 8'h00, "R3 cmd write");
        // R4
        write_xfer(8'h10, 3, 8'h59, 8'h23, 8'h3E, "R4 multi byte");
        // R5
        write_xfer(8'h10, 3, 8'h7F, 8'h1F, 8'hFF, "R5 unused codes");
        // R2: wrong addresses, following bytes ignored
        write_xfer(8'h12, 2, 8'h3F, 8'h5F, 8'h00, "R2 wrong address");
        write_xfer(8'h90, 1, 8'h21, 8'h00, 8'h00, "R2 wrong address high bit");
        // R6
        flags = 5'h15;
        read_xfer(8'h11, 2, "R6 status read");
        flags = 5'h0A;
        read_xfer(8'h11, 3, "R6 status read again");
        // R7
        pwr_ok = 1'b0;
        write_xfer(8'h10, 1, 8'h31, 8'h00, 8'h00, "R7 power low write");
        read_xfer(8'h11, 1, "R7 power low read");
        pwr_ok = 1'b1;
        i2c_start();
        send_byte(8'h10, a, st);
        chk("R7 address ack before drop", a, 1);
        pwr_ok = 1'b0;
        send_byte(8'h2F, a, st);
        chk("R7 data ack with power low", a, 0);
        pwr_ok = 1'b1;
        send_byte(8'h2E, a, st);
        chk("R7 no ack after drop", a, 0);
        finish_regs("R7 power drop");

        for (int k = 0; k < 40; k++) begin
            logic [7:0] ab;
            pwr_ok = ($urandom % 6) != 0;
            ab = ($urandom % 5 == 0) ? 8'($urandom) : 8'h10;
            flags = 5'($urandom);
            if ($urandom % 3 == 0) begin
                ab[0] = 1'b1;
                read_xfer(ab, 1 + int'($urandom % 2), "R6 random read");
            end else begin
                ab[0] = 1'b0;
                write_xfer(ab, 1 + int'($urandom % 3), 8'($urandom), 8'($urandom),
                           8'($urandom), "R4 random write");
            end
            pwr_ok = 1'b1;
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule